// File: doc/BRIEF.md
# Software Interrupt Trigger Dispatcher

This block turns one 32-bit write to a software-trigger register into pending software interrupts for a group of CPUs. Each write names an interrupt ID and a filter mode, and the requesting CPU number arrives on its own port. The filter mode picks the CPUs that receive the interrupt: the CPUs in an explicit eight-bit target list, every CPU except the requester, or only the requester. The fourth filter code is reserved, and a write that uses it raises nothing.

For each targeted CPU the block drives a single-cycle set pulse at the chosen ID. It keeps a pending bit for every CPU/ID pair and records which CPU asked for each one, so that acknowledge logic elsewhere can report the source. An external clear port drops one pending bit at a time. The security-attribute bit and the unused bits of the write are accepted and ignored.

Control is a two-state machine. `ST_IDLE` waits for a write. The transition `IDLE->FIRE` is taken when the write strobe is high and the decoded target set is not empty. `ST_FIRE` drives the set pulses for one cycle. From there, `FIRE->FIRE` is taken for a back-to-back write with a non-empty target set, and `FIRE->IDLE` is taken otherwise. A write whose target set is empty leaves the machine in, or returns it to, `ST_IDLE`.

Top module: `swi_dispatch`

## Requirements
- R1: After reset, every pending bit, every set pulse and every source field is zero.
- R2: The interrupt ID is taken from write bits 3:0, the target list from bits 23:16 (bit 16+c targets CPU c), and the filter mode from bits 25:24.
- R3: With filter 00, a write raises the ID on exactly the CPUs whose target-list bit is 1. The set-pulse bit for CPU c and ID i is bit c*16+i.
- R4: With filter 01, a write raises the ID on every CPU except the requesting CPU, whatever the target list holds.
- R5: With filter 10, a write raises the ID on the requesting CPU only.
- R6: With filter 11 (reserved), a write produces no set pulse.
- R7: With filter 00 and an all-zero target list, a write produces no set pulse.
- R8: Bit 15 (security attribute) and bits 31:26 and 14:4 have no effect on the pulses produced.
- R9: Set pulses are high during the one cycle after the clock edge that samples the write strobe. At the following edge the matching pending bits become 1, and they stay 1 until cleared.
- R10: For every entry it sets, a write stores the requesting CPU number in that entry's 3-bit source field (bits (c*16+i)*3 upward), overwriting any earlier value.
- R11: A clear strobe drops the pending bit of the selected CPU/ID at the next edge and leaves its source field unchanged. If a set pulse hits the same entry in that cycle, the set wins.
- R12: No set pulse appears without a write strobe in the previous cycle, and each write pulses for only one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the trigger register |
| wr_data | input | 32 | Trigger register write data |
| wr_cpu | input | 3 | Number of the CPU performing the write |
| clr_en | input | 1 | Clear strobe for one pending entry |
| clr_cpu | input | 3 | CPU of the entry to clear |
| clr_id | input | 4 | Interrupt ID of the entry to clear |
| set_pulse | output | 128 | One-cycle set pulse per CPU/ID, bit c*16+i |
| pend | output | 128 | Pending bit per CPU/ID, bit c*16+i |
| src_cpu | output | 384 | Requesting CPU per CPU/ID, 3 bits per entry |

## Verification
The hardest case to reach from the ports is a clear and a new set landing on the same entry at the same edge. The clear strobe must be driven in the single cycle in which the set pulse from an earlier write is high. The stimulus issues a write and then drives the clear for that exact CPU/ID right after the edge that samples the strobe, so that both meet at the next edge. The bench then checks that the entry is still pending. Source overwrite is reached by having two different CPUs target the same entry one after the other, and the bench confirms that a neighbouring entry keeps the older source.

// File: rtl/swi_pkg.sv
`timescale 1ns/1ps
package swi_pkg;

    // Filter mode field encoding
    typedef enum logic [1:0] {
        FLT_LIST   = 2'b00,
        FLT_OTHERS = 2'b01,
        FLT_SELF   = 2'b10,
        FLT_RSVD   = 2'b11
    } flt_e;

    // Dispatcher control states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FIRE = 1'b1
    } st_e;

    // Field positions inside the trigger word
    localparam int FLT_LSB  = 24;
    localparam int LIST_LSB = 16;
    localparam int LIST_W   = 8;
    localparam int ID_LSB   = 0;

endpackage

// File: rtl/swi_decode.sv
`timescale 1ns/1ps
module swi_decode
    import swi_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic [31:0]       wr_data,
    output flt_e              flt,
    output logic [LIST_W-1:0] list,
    output logic [ID_W-1:0]   id
);

    // Security attribute and spare bits are accepted but carry no function.
    logic spare_unused;

    assign flt  = flt_e'(wr_data[FLT_LSB +: 2]);
    assign list = wr_data[LIST_LSB +: LIST_W];
    assign id   = wr_data[ID_LSB +: ID_W];
    assign spare_unused = ^{wr_data[31:FLT_LSB+2], wr_data[LIST_LSB-1:ID_LSB+ID_W]};

endmodule

// File: rtl/swi_target.sv
`timescale 1ns/1ps
module swi_target
    import swi_pkg::*;
#(
    parameter int NCPU  = 8,
    parameter int CPU_W = 3
) (
    input  flt_e              flt,
    input  logic [LIST_W-1:0] list,
    input  logic [CPU_W-1:0]  req_cpu,
    output logic [NCPU-1:0]   mask
);

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic is_req;
        assign is_req = (req_cpu == CPU_W'(c));

        always_comb begin
            unique case (flt)
                FLT_LIST:   mask[c] = list[c];
                FLT_OTHERS: mask[c] = !is_req;
                FLT_SELF:   mask[c] = is_req;
                FLT_RSVD:   mask[c] = 1'b0;
                default:    mask[c] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/swi_pend_bank.sv
`timescale 1ns/1ps
module swi_pend_bank #(
    parameter int NENT  = 128,
    parameter int CPU_W = 3,
    localparam int ENT_W = $clog2(NENT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NENT-1:0]       set_vec,
    input  logic [CPU_W-1:0]      src_in,
    input  logic                  clr_en,
    input  logic [ENT_W-1:0]      clr_idx,
    output logic [NENT-1:0]       pend,
    output logic [NENT*CPU_W-1:0] src_flat
);

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        // Pending flag: a set on the same edge wins over a clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[e] <= 1'b0;
            end else if (set_vec[e]) begin
                pend[e] <= 1'b1;
            end else if (clr_en && (clr_idx == ENT_W'(e))) begin
                pend[e] <= 1'b0;
            end
        end

        // Source record: overwritten by each new set, untouched by clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_flat[e*CPU_W +: CPU_W] <= '0;
            end else if (set_vec[e]) begin
                src_flat[e*CPU_W +: CPU_W] <= src_in;
            end
        end
    end

endmodule

// File: rtl/swi_dispatch.sv
`timescale 1ns/1ps
module swi_dispatch
    import swi_pkg::*;
#(
    parameter int NCPU = 8,
    parameter int NID  = 16,
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int ID_W  = (NID > 1) ? $clog2(NID) : 1,
    localparam int NENT  = NCPU * NID,
    localparam int ENT_W = $clog2(NENT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [31:0]           wr_data,
    input  logic [CPU_W-1:0]      wr_cpu,
    input  logic                  clr_en,
    input  logic [CPU_W-1:0]      clr_cpu,
    input  logic [ID_W-1:0]       clr_id,
    output logic [NENT-1:0]       set_pulse,
    output logic [NENT-1:0]       pend,
    output logic [NENT*CPU_W-1:0] src_cpu
);

    flt_e              dec_flt;
    logic [LIST_W-1:0] dec_list;
    logic [ID_W-1:0]   dec_id;
    logic [NCPU-1:0]   tgt_mask;

    st_e               state_q, state_d;
    logic [NCPU-1:0]   mask_q;
    logic [ID_W-1:0]   id_q;
    logic [CPU_W-1:0]  cpu_q;
    logic              accept;
    logic [ENT_W-1:0]  clr_idx;

    swi_decode #(.ID_W(ID_W)) u_dec (
        .wr_data (wr_data),
        .flt     (dec_flt),
        .list    (dec_list),
        .id      (dec_id)
    );

    swi_target #(.NCPU(NCPU), .CPU_W(CPU_W)) u_tgt (
        .flt     (dec_flt),
        .list    (dec_list),
        .req_cpu (wr_cpu),
        .mask    (tgt_mask)
    );

    // A write is taken only when it reaches at least one CPU.
    assign accept = wr_en && (|tgt_mask);

    // Next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_FIRE : ST_IDLE;
            ST_FIRE: state_d = accept ? ST_FIRE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            id_q   <= '0;
            cpu_q  <= '0;
        end else if (accept) begin
            mask_q <= tgt_mask;
            id_q   <= dec_id;
            cpu_q  <= wr_cpu;
        end
    end

    // Outputs: pulse grid driven only in the fire state
    always_comb begin
        set_pulse = '0;
        unique case (state_q)
            ST_FIRE: begin
                for (int c = 0; c < NCPU; c++) begin
                    for (int i = 0; i < NID; i++) begin
                        set_pulse[c*NID + i] = mask_q[c] && (id_q == ID_W'(i));
                    end
                end
            end
            ST_IDLE: set_pulse = '0;
            default: set_pulse = '0;
        endcase
    end

    assign clr_idx = ENT_W'(clr_cpu) * ENT_W'(NID) + ENT_W'(clr_id);

    swi_pend_bank #(.NENT(NENT), .CPU_W(CPU_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_pulse),
        .src_in   (cpu_q),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx),
        .pend     (pend),
        .src_flat (src_cpu)
    );

endmodule

// File: rtl/swi_dispatch_chk.sv
`timescale 1ns/1ps
module swi_dispatch_chk #(
    parameter int NCPU = 8,
    parameter int NID  = 16,
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int ID_W  = (NID > 1) ? $clog2(NID) : 1,
    localparam int NENT  = NCPU * NID,
    localparam int ENT_W = $clog2(NENT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [31:0]      wr_data,
    input logic             clr_en,
    input logic [CPU_W-1:0] clr_cpu,
    input logic [ID_W-1:0]  clr_id,
    input logic [NENT-1:0]  set_pulse,
    input logic [NENT-1:0]  pend
);

    logic [ENT_W-1:0] chk_idx, chk_idx_q;
    assign chk_idx = ENT_W'(clr_cpu) * ENT_W'(NID) + ENT_W'(clr_id);

    always_ff @(posedge clk) begin
        if (!rst_n) chk_idx_q <= '0;
        else        chk_idx_q <= chk_idx;
    end

    assert_pulse_needs_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_pulse) |-> $past(wr_en));

    assert_reserved_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25:24] == 2'b11) |=> (set_pulse == '0));

    assert_self_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25:24] == 2'b10) |=> ($countones(set_pulse) == 1));

    assert_others_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25:24] == 2'b01) |=> ($countones(set_pulse) == NCPU - 1));

    assert_empty_list_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25:24] == 2'b00 && wr_data[23:16] == 8'h00) |=> (set_pulse == '0));

    assert_pend_follows_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_pulse) |=> ((pend & $past(set_pulse)) == $past(set_pulse)));

    assert_clear_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_pulse[chk_idx]) |=> !pend[chk_idx_q]);

endmodule

bind swi_dispatch swi_dispatch_chk #(.NCPU(NCPU), .NID(NID)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .clr_en    (clr_en),
    .clr_cpu   (clr_cpu),
    .clr_id    (clr_id),
    .set_pulse (set_pulse),
    .pend      (pend)
);

// File: tb/swi_dispatch_tb.sv
`timescale 1ns/1ps
module swi_dispatch_tb;

    localparam int NCPU = 8;
    localparam int NID  = 16;
    localparam int NENT = NCPU * NID;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [31:0]       wr_data = '0;
    logic [2:0]        wr_cpu = '0;
    logic              clr_en = 1'b0;
    logic [2:0]        clr_cpu = '0;
    logic [3:0]        clr_id = '0;
    logic [NENT-1:0]   set_pulse;
    logic [NENT-1:0]   pend;
    logic [NENT*3-1:0] src_cpu;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    swi_dispatch #(.NCPU(NCPU), .NID(NID)) u_dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
        .wr_cpu (wr_cpu), .clr_en (clr_en), .clr_cpu (clr_cpu), .clr_id (clr_id),
        .set_pulse (set_pulse), .pend (pend), .src_cpu (src_cpu)
    );

    typedef struct packed {
        logic [2:0]  cpu;
        logic [31:0] data;
        logic [7:0]  exp;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{3'd0, 32'h00A5_0007, 8'hA5},  // list mode
        '{3'd3, 32'h0100_0002, 8'hF7},  // all but requester
        '{3'd6, 32'h0200_000F, 8'h40},  // requester only
        '{3'd2, 32'h03FF_0001, 8'h00},  // reserved filter
        '{3'd1, 32'h0000_0004, 8'h00},  // list mode, empty list
        '{3'd5, 32'h0200_8003, 8'h20},  // requester only, security bit set
        '{3'd4, 32'hFCFF_FFF9, 8'hFF},  // list mode, spare bits set
        '{3'd7, 32'h0181_0000, 8'h7F},  // all but requester, list ignored
        '{3'd0, 32'h0100_000C, 8'hFE}   // all but requester, CPU 0 writes
    };

    function automatic logic [NENT-1:0] expand(input logic [7:0] m, input logic [3:0] id);
        logic [NENT-1:0] r = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (m[c]) r[c*NID + int'(id)] = 1'b1;
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [31:0] d);
        case (d[25:24])
            2'b11:   return "R6";
            2'b10:   return "R5";
            2'b01:   return "R4";
            default: return (d[23:16] == 8'h00) ? "R7" : "R2/R3";
        endcase
    endfunction

    function automatic logic [2:0] src_at(input int c, input int i);
        return src_cpu[(c*NID + i)*3 +: 3];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [NENT-1:0] act, input logic [NENT-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Returns at the falling edge right after the edge that sampled the strobe.
    task automatic do_write(input logic [2:0] cpu, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_cpu = cpu;
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    initial begin
        do_reset();

        // R1: reset state
        chk("R1", "pend after reset", pend, '0);
        chk("R1", "set_pulse after reset", set_pulse, '0);
        chk("R1", "src any bit after reset", NENT'(|src_cpu), '0);

        // Table walk: R2..R8 pulse patterns, R12 single-cycle pulse
        for (int k = 0; k < 9; k++) begin
            do_write(VECS[k].cpu, VECS[k].data);
            chk(tag_of(VECS[k].data), $sformatf("pulse vector %0d", k),
                set_pulse, expand(VECS[k].exp, VECS[k].data[3:0]));
            @(negedge clk);
            chk("R12", $sformatf("pulse gone after vector %0d", k), set_pulse, '0);
        end

        // R8: security bit and spare bits do not change the result
        do_write(3'd1, 32'hFC02_FFF6);
        chk("R8", "spare and security bits ignored", set_pulse, expand(8'h02, 4'd6));
        @(negedge clk);

        // R12: data without strobe raises nothing
        wr_data = 32'h00FF_0003;
        repeat (2) @(negedge clk);
        chk("R12", "no strobe no pulse", set_pulse, '0);
        wr_data = '0;

        do_reset();

        // R9: pending set one edge after the pulse, then held
        do_write(3'd2, 32'h0011_0005);
        @(negedge clk);
        chk("R9", "pend after write", pend, expand(8'h11, 4'd5));
        repeat (3) @(negedge clk);
        chk("R9", "pend held", pend, expand(8'h11, 4'd5));

        // R10: source recorded and overwritten
        chk("R10", "src cpu0 id5", NENT'(src_at(0, 5)), NENT'(3'd2));
        do_write(3'd6, 32'h0001_0005);
        @(negedge clk);
        chk("R10", "src cpu0 id5 overwritten", NENT'(src_at(0, 5)), NENT'(3'd6));
        chk("R10", "src cpu4 id5 kept", NENT'(src_at(4, 5)), NENT'(3'd2));

        // R11: clear one entry, source untouched
        clr_en = 1'b1; clr_cpu = 3'd0; clr_id = 4'd5;
        @(negedge clk);
        clr_en = 1'b0;
        chk("R11", "pend after clear", pend, expand(8'h10, 4'd5));
        chk("R11", "src kept after clear", NENT'(src_at(0, 5)), NENT'(3'd6));

        // R11: set and clear on the same entry at the same edge, set wins
        do_write(3'd3, 32'h0002_0008);
        clr_en = 1'b1; clr_cpu = 3'd1; clr_id = 4'd8;
        @(negedge clk);
        clr_en = 1'b0;
        chk("R11", "set beats clear", pend, expand(8'h10, 4'd5) | expand(8'h02, 4'd8));
        chk("R10", "src of collided entry", NENT'(src_at(1, 8)), NENT'(3'd3));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule